// File: doc/BRIEF.md
# RC6 Mode-0 Infrared Frame Transmitter

This block turns an 8-bit address, an 8-bit command byte and a toggle flag into one complete RC6 mode-0 infrared frame. A single-cycle start strobe captures the three fields and launches the frame. The frame is a long carrier burst and a quiet gap, then a start bit, three mode bits, a toggle bit of double length, and sixteen payload bits. The payload bits are sent with mark-first biphase coding. The block drives an envelope output and a carrier-gated output that can go straight to an LED driver. It holds busy for the whole frame and pulses done once the last interval has ended.

All timing comes from one clock divider, which is set by the clock and carrier frequencies. One divider period is one carrier cycle and one tick. A half-bit unit is a parameterised number of ticks. With the defaults, one unit is 16 carrier cycles at 36 kHz, which is 444 µs. The leader is 6 units of mark and 2 units of space. The toggle bit halves are 2 units each. The carrier is on for the first part of each divider period, set by a duty-cycle parameter, and the divider restarts on every launch.

Top module: `rc6m0_ir_tx`

## Requirements
- R1: After reset, busy_o, done_o, mark_o and ir_o are all 0.
- R2: The frame opens with mark_o high for LEAD_MARK_UNITS units (default 6), followed by mark_o low for LEAD_SPACE_UNITS units (default 2). A unit is UNIT_TICKS ticks, and a tick is CLK_HZ/CARRIER_HZ clock cycles.
- R3: After the leader come a start bit of value 1 and then three mode bits of value 0. Each half of these bits lasts one unit.
- R4: Each bit has two halves. A 1 is sent as mark then space, and a 0 as space then mark.
- R5: The toggle bit comes straight after the mode bits. It carries toggle_i and each of its halves lasts DOUBLE_UNITS units (default 2).
- R6: The sixteen payload bits come last, one unit per half. They are the address byte followed by the data byte, and each byte is sent MSB first.
- R7: ir_o equals mark_o ANDed with a carrier. The carrier is high for the first DIV*DUTY_PCT/100 clocks of each DIV-clock period. Its phase restarts at the clock edge that accepts a start.
- R8: busy_o and the first leader mark rise one cycle after the accepting edge. busy_o stays high for exactly the total frame length of 52 units. It then falls together with mark_o, and done_o pulses high for exactly that one cycle.
- R9: A start_i pulse while busy_o is high, with any field values, is ignored: the frame in progress continues unchanged.
- R10: Adjacent halves at the same level merge into one steady level. mark_o changes only on a unit boundary, never inside a unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch strobe, accepted only when idle |
| addr_i | input | 8 | Address byte, sent first in the payload |
| data_i | input | 8 | Data byte, sent second in the payload |
| toggle_i | input | 1 | Value of the double-length toggle bit |
| busy_o | output | 1 | High while a frame is being sent |
| done_o | output | 1 | One-cycle pulse when the frame ends |
| mark_o | output | 1 | Unmodulated envelope, 1 during marks |
| ir_o | output | 1 | Envelope gated by the carrier |

## Verification
The bench walks a single 1 across all sixteen payload positions, flips the toggle flag, and adds all-zero, all-one and alternating words. For every cycle it compares the envelope and the gated output against an arithmetic model. A wrong half-length, a swapped biphase polarity or a byte-order slip shows up as a mismatch in the exact unit that moves.

It also covers these cases:
- Same-level halves that must merge, such as the start-bit space running into the first mode-bit space. A design that broke here would show a one-cycle dip.
- The doubled toggle halves. A design that treated them as single would shift every later bit early.
- A mid-frame start with inverted fields. A design that reloaded would corrupt the rest of the frame.
- The exact cycle where busy falls and done pulses. A design that ended early would cut off the last payload half.

// File: rtl/rc6_tx_pkg.sv
package rc6_tx_pkg;

   localparam int HDR_BITS   = 5;
   localparam int WORD_BITS  = 16;
   localparam int NUM_SEGS   = 2 + 2 * (HDR_BITS + WORD_BITS);
   localparam int SEG_W      = 6;
   localparam int FRM_W      = WORD_BITS + 1;

   typedef enum logic [1:0] {
      SEG_LEAD_MARK,
      SEG_LEAD_SPACE,
      SEG_SINGLE,
      SEG_DOUBLE
   } seg_kind_e;

   // Segment 0/1 are the leader; after that every two segments form one bit.
   function automatic seg_kind_e seg_kind(input logic [SEG_W-1:0] seg);
      logic [SEG_W-1:0] rel;
      rel = seg - SEG_W'(2);
      if (seg == SEG_W'(0))      return SEG_LEAD_MARK;
      else if (seg == SEG_W'(1)) return SEG_LEAD_SPACE;
      else if (rel[SEG_W-1:1] == 5'd4) return SEG_DOUBLE;
      else                       return SEG_SINGLE;
   endfunction

   // frm = {toggle, addr, data}
   function automatic logic seg_level(input logic [SEG_W-1:0] seg,
                                      input logic [FRM_W-1:0] frm);
      logic [SEG_W-1:0] rel;
      logic [4:0]       bi;
      logic             bitv;
      rel = seg - SEG_W'(2);
      bi  = rel[SEG_W-1:1];
      if (seg == SEG_W'(0)) return 1'b1;
      if (seg == SEG_W'(1)) return 1'b0;
      if (bi == 5'd0)      bitv = 1'b1;
      else if (bi < 5'd4)  bitv = 1'b0;
      else if (bi == 5'd4) bitv = frm[FRM_W-1];
      else                 bitv = frm[5'd20 - bi];
      // mark-first biphase: first half carries the bit, second its inverse
      return rel[0] ? ~bitv : bitv;
   endfunction

endpackage

// File: rtl/rc6_tick_gen.sv
module rc6_tick_gen #(
   parameter int DIV = 333,
   localparam int PW = (DIV > 1) ? $clog2(DIV) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   output logic          tick_o,
   output logic [PW-1:0] phase_o
);

   logic [PW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cnt_q <= '0;
      else if (clr_i)                   cnt_q <= '0;
      else if (cnt_q == PW'(DIV - 1))   cnt_q <= '0;
      else                              cnt_q <= cnt_q + PW'(1);
   end

   assign tick_o  = (cnt_q == PW'(DIV - 1));
   assign phase_o = cnt_q;

endmodule

// File: rtl/rc6_carrier_gate.sv
module rc6_carrier_gate #(
   parameter int DIV    = 333,
   parameter int HIGH   = 99,
   parameter bit ENABLE = 1'b1,
   localparam int PW = (DIV > 1) ? $clog2(DIV) : 1
) (
   input  logic [PW-1:0] phase_i,
   input  logic          mark_i,
   output logic          ir_o
);

   generate
      if (ENABLE) begin : g_mod
         logic carrier;
         assign carrier = (phase_i < PW'(HIGH));
         assign ir_o    = mark_i & carrier;
      end else begin : g_base
         logic unused_phase;
         assign unused_phase = ^phase_i;
         assign ir_o         = mark_i;
      end
   endgenerate

endmodule

// File: rtl/rc6_frame_seq.sv
module rc6_frame_seq
   import rc6_tx_pkg::*;
#(
   parameter int UNIT_TICKS       = 16,
   parameter int LEAD_MARK_UNITS  = 6,
   parameter int LEAD_SPACE_UNITS = 2,
   parameter int DOUBLE_UNITS     = 2,
   localparam int MAXU = (LEAD_MARK_UNITS > LEAD_SPACE_UNITS)
                         ? ((LEAD_MARK_UNITS > DOUBLE_UNITS) ? LEAD_MARK_UNITS : DOUBLE_UNITS)
                         : ((LEAD_SPACE_UNITS > DOUBLE_UNITS) ? LEAD_SPACE_UNITS : DOUBLE_UNITS),
   localparam int UW = (MAXU > 1) ? $clog2(MAXU) : 1,
   localparam int TW = (UNIT_TICKS > 1) ? $clog2(UNIT_TICKS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [7:0]       addr_i,
   input  logic [7:0]       data_i,
   input  logic             toggle_i,
   input  logic             tick_i,
   output logic             launch_o,
   output logic             busy_o,
   output logic             done_o,
   output logic             mark_o,
   output logic [FRM_W-1:0] frame_o
);

   logic             busy_q, done_q, mark_q;
   logic [SEG_W-1:0] seg_q;
   logic [TW-1:0]    tq;
   logic [UW-1:0]    uq;
   logic [UW-1:0]    u_last;
   logic [FRM_W-1:0] frame_q;
   logic             unit_end, seg_end, frame_end;

   always_comb begin
      case (seg_kind(seg_q))
         SEG_LEAD_MARK:  u_last = UW'(LEAD_MARK_UNITS - 1);
         SEG_LEAD_SPACE: u_last = UW'(LEAD_SPACE_UNITS - 1);
         SEG_DOUBLE:     u_last = UW'(DOUBLE_UNITS - 1);
         default:        u_last = '0;
      endcase
   end

   assign launch_o  = start_i & ~busy_q;
   assign unit_end  = tick_i && (tq == TW'(UNIT_TICKS - 1));
   assign seg_end   = unit_end && (uq == u_last);
   assign frame_end = seg_end && (seg_q == SEG_W'(NUM_SEGS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         mark_q  <= 1'b0;
         seg_q   <= '0;
         tq      <= '0;
         uq      <= '0;
         frame_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (launch_o) begin
            busy_q  <= 1'b1;
            seg_q   <= '0;
            tq      <= '0;
            uq      <= '0;
            frame_q <= {toggle_i, addr_i, data_i};
            mark_q  <= seg_level(SEG_W'(0), {toggle_i, addr_i, data_i});
         end else if (busy_q && tick_i) begin
            if (!unit_end) begin
               tq <= tq + TW'(1);
            end else begin
               tq <= '0;
               if (!seg_end) begin
                  uq <= uq + UW'(1);
               end else if (frame_end) begin
                  uq     <= '0;
                  busy_q <= 1'b0;
                  mark_q <= 1'b0;
                  done_q <= 1'b1;
               end else begin
                  uq     <= '0;
                  seg_q  <= seg_q + SEG_W'(1);
                  mark_q <= seg_level(seg_q + SEG_W'(1), frame_q);
               end
            end
         end
      end
   end

   assign busy_o  = busy_q;
   assign done_o  = done_q;
   assign mark_o  = mark_q;
   assign frame_o = frame_q;

endmodule

// File: rtl/rc6m0_ir_tx.sv
module rc6m0_ir_tx
   import rc6_tx_pkg::*;
#(
   parameter int CLK_HZ           = 12_000_000,
   parameter int CARRIER_HZ       = 36_000,
   parameter int DUTY_PCT         = 30,
   parameter int UNIT_TICKS       = 16,
   parameter int LEAD_MARK_UNITS  = 6,
   parameter int LEAD_SPACE_UNITS = 2,
   parameter int DOUBLE_UNITS     = 2,
   parameter bit CARRIER_EN       = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic [7:0] addr_i,
   input  logic [7:0] data_i,
   input  logic       toggle_i,
   output logic       busy_o,
   output logic       done_o,
   output logic       mark_o,
   output logic       ir_o
);

   localparam int DIV  = CLK_HZ / CARRIER_HZ;
   localparam int HIGH = DIV * DUTY_PCT / 100;
   localparam int PW   = (DIV > 1) ? $clog2(DIV) : 1;

   generate
      if (DIV < 2) begin : g_bad_div
         $error("clock must be at least twice the carrier frequency");
      end
      if (HIGH < 1 || HIGH >= DIV) begin : g_bad_duty
         $error("duty cycle must give between 1 and DIV-1 high clocks");
      end
      if (UNIT_TICKS < 1 || LEAD_MARK_UNITS < 1 || LEAD_SPACE_UNITS < 1 || DOUBLE_UNITS < 1) begin : g_bad_len
         $error("all interval lengths must be at least one");
      end
   endgenerate

   logic             tick_w;
   logic             launch_w;
   logic [PW-1:0]    phase_w;
   logic [FRM_W-1:0] frame_w;

   rc6_tick_gen #(.DIV(DIV)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (launch_w),
      .tick_o  (tick_w),
      .phase_o (phase_w)
   );

   rc6_frame_seq #(
      .UNIT_TICKS       (UNIT_TICKS),
      .LEAD_MARK_UNITS  (LEAD_MARK_UNITS),
      .LEAD_SPACE_UNITS (LEAD_SPACE_UNITS),
      .DOUBLE_UNITS     (DOUBLE_UNITS)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .addr_i   (addr_i),
      .data_i   (data_i),
      .toggle_i (toggle_i),
      .tick_i   (tick_w),
      .launch_o (launch_w),
      .busy_o   (busy_o),
      .done_o   (done_o),
      .mark_o   (mark_o),
      .frame_o  (frame_w)
   );

   rc6_carrier_gate #(.DIV(DIV), .HIGH(HIGH), .ENABLE(CARRIER_EN)) u_gate (
      .phase_i (phase_w),
      .mark_i  (mark_o),
      .ir_o    (ir_o)
   );

endmodule

// File: rtl/rc6m0_ir_tx_chk.sv
module rc6m0_ir_tx_chk
   import rc6_tx_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic             busy_o,
   input logic             done_o,
   input logic             mark_o,
   input logic             ir_o,
   input logic             tick_w,
   input logic [FRM_W-1:0] frame_w
);

   assert_leader_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> mark_o);

   assert_gate_under_mark_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ir_o |-> mark_o);

   assert_done_on_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o)));

   assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_idle_dark_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!mark_o && !ir_o));

   assert_frame_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> $stable(frame_w));

   assert_edge_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o) && (mark_o != $past(mark_o))) |-> $past(tick_w));

endmodule

bind rc6m0_ir_tx rc6m0_ir_tx_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .busy_o  (busy_o),
   .done_o  (done_o),
   .mark_o  (mark_o),
   .ir_o    (ir_o),
   .tick_w  (tick_w),
   .frame_w (frame_w)
);

// File: tb/sim_rc6m0_ir_tx.sv
module sim_rc6m0_ir_tx;

   localparam int DIV       = 4;
   localparam int HIGH      = 2;
   localparam int UT        = 2;
   localparam int CPU       = DIV * UT;
   localparam int TOTAL_U   = 52;
   localparam int FRAME_CYC = TOTAL_U * CPU;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [7:0] addr = '0;
   logic [7:0] data = '0;
   logic       tog = 1'b0;
   logic       busy, done, mark, ir;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   rc6m0_ir_tx #(
      .CLK_HZ(144_000), .CARRIER_HZ(36_000), .DUTY_PCT(50), .UNIT_TICKS(UT)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start), .addr_i(addr), .data_i(data),
      .toggle_i(tog), .busy_o(busy), .done_o(done), .mark_o(mark), .ir_o(ir)
   );

   task automatic check_bit(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual %0b expected %0b at %0t", req, what, act, exp, $time);
      end
   endtask

   // Envelope level of unit u: leader 6+2, start 1, mode 000, toggle doubled, payload.
   function automatic logic exp_level(input int u, input logic [15:0] w, input logic t);
      int j;
      logic b;
      if (u < 6) return 1'b1;
      if (u < 8) return 1'b0;
      if (u < 10) return (u == 8);
      if (u < 16) return ((u - 10) % 2 == 1);
      if (u < 20) return ((u - 16) / 2 == 1) ? ~t : t;
      j = u - 20;
      b = w[15 - j / 2];
      return (j % 2 == 1) ? ~b : b;
   endfunction

   function automatic string tag_of(input int u);
      if (u < 8)  return "R2";
      if (u < 16) return "R3 R4 R10";
      if (u < 20) return "R4 R5";
      return "R4 R6";
   endfunction

   task automatic run_frame(input logic [7:0] a, input logic [7:0] d, input logic t, input bit poke);
      logic el;
      int   u;
      string req;
      @(negedge clk);
      addr = a; data = d; tog = t; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int c = 0; c <= FRAME_CYC + 1; c++) begin
         if (poke && c == 100) begin
            start = 1'b1; addr = ~a; data = ~d; tog = ~t;
         end
         if (poke && c == 101) start = 1'b0;
         if (c < FRAME_CYC) begin
            u   = c / CPU;
            el  = exp_level(u, {a, d}, t);
            req = (poke && c > 100) ? "R9" : tag_of(u);
            check_bit(req, "mark_o", mark, el);
            check_bit("R7", "ir_o", ir, el && ((c % DIV) < HIGH));
            check_bit("R8", "busy_o", busy, 1'b1);
            check_bit("R8", "done_o", done, 1'b0);
         end else if (c == FRAME_CYC) begin
            check_bit("R8", "busy_o end", busy, 1'b0);
            check_bit("R8", "done_o end", done, 1'b1);
            check_bit("R8", "mark_o end", mark, 1'b0);
            check_bit("R8", "ir_o end", ir, 1'b0);
         end else begin
            check_bit("R8", "done_o after", done, 1'b0);
            check_bit("R8", "busy_o after", busy, 1'b0);
         end
         @(negedge clk);
      end
   endtask

   task automatic summary;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check_bit("R1", "busy_o reset", busy, 1'b0);
      check_bit("R1", "done_o reset", done, 1'b0);
      check_bit("R1", "mark_o reset", mark, 1'b0);
      check_bit("R1", "ir_o reset", ir, 1'b0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check_bit("R1", "busy_o idle", busy, 1'b0);
      check_bit("R1", "ir_o idle", ir, 1'b0);

      run_frame(8'h00, 8'h00, 1'b0, 1'b0);
      run_frame(8'hFF, 8'hFF, 1'b1, 1'b0);
      run_frame(8'hA5, 8'h5A, 1'b0, 1'b1);
      for (int k = 0; k < 16; k++) begin
         logic [15:0] w;
         w = 16'h0001 << k;
         run_frame(w[15:8], w[7:0], k[0], 1'b0);
      end
      run_frame(8'h3C, 8'hC3, 1'b1, 1'b1);

      finished = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired after 200000 cycles");
         summary();
         $finish;
      end
   end

endmodule